// File: doc/BRIEF.md
# Adaptive Leaky Integrate-and-Fire Neuron

This block is a clocked, fully digital spiking neuron. Signed input events, each marked by a valid strobe, are added into an unsigned membrane accumulator. A separate time-step tick advances the neuron's dynamics. On each tick the membrane loses a programmable leak amount and the present adaptation level, and it is then compared with a threshold that can be rewritten at run time. When the membrane reaches the threshold, the neuron emits a single-cycle spike, clears the membrane and enters a refractory hold-off. The hold-off lasts a programmable number of ticks.

Every spike raises an internal adaptation level by a programmable increment. This level drags the membrane down on every following tick, so under steady drive the spikes come further apart. The level decays by a programmable right shift on each tick. A network scheduler drives the tick at the model's time-step rate and streams synaptic events in between. It reads the spike pulse, and it can watch the membrane value for debug.

Top module: `alif_neuron`

## Requirements
- R1: In a cycle with `inValid` high and no refractory hold-off active, the signed `inCurrent` is added to the membrane, and the sum appears on `membrane` after the next clock edge. In a cycle with neither `inValid` nor `tick`, the membrane does not change.
- R2: In a cycle with `tick` high, the value `cfgLeak` plus the present adaptation level is subtracted from the membrane, after any input accepted in that same cycle has been added. Any result below zero is held at zero.
- R3: The membrane saturates at 2^MEM_W-1 and never wraps. A later negative input counts down from that ceiling.
- R4: A tick whose resulting membrane is greater than or equal to `cfgThresh`, with no hold-off active, fires the neuron. `spike` is high for exactly the cycle after that tick cycle, and `membrane` reads 0 in that cycle.
- R5: A firing loads the hold-off counter with `cfgRefrac`, and each later tick lowers the counter by one. While the counter is nonzero, inputs are ignored and the neuron cannot fire. A `cfgRefrac` of 0 allows firing again on the very next tick.
- R6: On each tick the adaptation level becomes the old level shifted right by `cfgAdaptShift`. On a firing tick `cfgAdaptInc` is also added, saturating at 2^ADAPT_W-1. The membrane subtraction of R2 uses the level from before the decay.
- R7: `cfgThresh` is read live at each tick, so a new value applies from the next tick on.
- R8: After reset the membrane, spike, adaptation level and hold-off counter are all zero.
- R9: Under sustained identical input, a nonzero adaptation increment gives fewer spikes than an increment of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input event strobe |
| inCurrent | input | IN_W | Signed synaptic input weight |
| tick | input | 1 | Time-step advance |
| cfgLeak | input | MEM_W | Leak amount per tick |
| cfgThresh | input | MEM_W | Firing threshold |
| cfgRefrac | input | REF_W | Refractory length in ticks |
| cfgAdaptInc | input | ADAPT_W | Adaptation increment per spike |
| cfgAdaptShift | input | SHIFT_W | Adaptation decay right-shift per tick |
| spike | output | 1 | One-cycle spike pulse |
| membrane | output | MEM_W | Membrane value for observation |

## Verification
Every result here is due exactly one edge after the cycle that causes it. That covers membrane changes from inputs and ticks, the spike pulse, and the clearing of the membrane on a firing. The bench drives each stimulus for one cycle and then reads `spike` and `membrane` just after the following rising edge, before it drives anything new. The adaptation level and the hold-off counter have no port of their own. The bench therefore infers them from how much later ticks remove from the membrane and from which inputs are dropped, with the expected values worked out by hand, tick by tick, in the vector table.

// File: rtl/alif_pkg.sv
package alif_pkg;
  // Strobes the control half hands to the datapath every cycle.
  typedef struct packed {
    logic acceptIn;   // add the input word this cycle
    logic applyStep;  // apply leak, adaptation drag and decay this cycle
  } ctlStrobes_t;
endpackage

// File: rtl/alif_ctrl.sv
module alif_ctrl
  import alif_pkg::*;
#(
  parameter int REF_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             tick,
  input  logic             overThresh,
  input  logic [REF_W-1:0] cfgRefrac,
  output ctlStrobes_t      strobes,
  output logic             fireNow,
  output logic             refBusy,
  output logic             spikeQ
);
  logic [REF_W-1:0] refCnt;

  assign refBusy           = (refCnt != '0);
  assign strobes.acceptIn  = inValid && !refBusy;
  assign strobes.applyStep = tick;
  assign fireNow           = tick && !refBusy && overThresh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt <= '0;
      spikeQ <= 1'b0;
    end else begin
      spikeQ <= fireNow;
      if (fireNow)
        refCnt <= cfgRefrac;
      else if (tick && refBusy)
        refCnt <= refCnt - 1'b1;
    end
  end

  AST_REFRAC_NO_SPIKE: assert property (@(posedge clk) disable iff (!rstN)
    refBusy |=> !spikeQ); // R5

endmodule

// File: rtl/alif_datapath.sv
module alif_datapath
  import alif_pkg::*;
#(
  parameter int MEM_W   = 16,
  parameter int IN_W    = 12,
  parameter int ADAPT_W = 12,
  parameter int SHIFT_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobes_t            strobes,
  input  logic                   fireNow,
  input  logic                   inValid,
  input  logic                   tick,
  input  logic signed [IN_W-1:0] inCurrent,
  input  logic [MEM_W-1:0]       cfgLeak,
  input  logic [MEM_W-1:0]       cfgThresh,
  input  logic [ADAPT_W-1:0]     cfgAdaptInc,
  input  logic [SHIFT_W-1:0]     cfgAdaptShift,
  output logic                   overThresh,
  output logic [MEM_W-1:0]       memQ
);
  localparam int SUM_W = MEM_W + 3;
  localparam logic [MEM_W-1:0] MEM_MAX = {MEM_W{1'b1}};
  localparam logic signed [SUM_W-1:0] MEM_MAX_S = $signed({3'b000, MEM_MAX});

  logic [ADAPT_W-1:0]      adaptQ;
  logic [ADAPT_W-1:0]      adaptD;
  logic [ADAPT_W-1:0]      adaptDecayed;
  logic [ADAPT_W:0]        adaptSum;
  logic signed [SUM_W-1:0] rawSum;
  logic [MEM_W-1:0]        clamped;
  logic [MEM_W-1:0]        memD;

  // Membrane arithmetic: input first, then leak and adaptation drag.
  always_comb begin
    rawSum = $signed({{(SUM_W-MEM_W){1'b0}}, memQ});
    if (strobes.acceptIn)
      rawSum = rawSum + $signed({{(SUM_W-IN_W){inCurrent[IN_W-1]}}, inCurrent});
    if (strobes.applyStep)
      rawSum = rawSum
             - $signed({{(SUM_W-MEM_W){1'b0}}, cfgLeak})
             - $signed({{(SUM_W-ADAPT_W){1'b0}}, adaptQ});
  end

  always_comb begin
    if (rawSum < 0)
      clamped = '0;
    else if (rawSum > MEM_MAX_S)
      clamped = MEM_MAX;
    else
      clamped = rawSum[MEM_W-1:0];
  end

  assign overThresh = (clamped >= cfgThresh);
  assign memD       = fireNow ? '0 : clamped;

  // Adaptation level: decays every tick, grows on a firing.
  assign adaptDecayed = adaptQ >> cfgAdaptShift;
  assign adaptSum     = {1'b0, adaptDecayed} + {1'b0, cfgAdaptInc};

  always_comb begin
    adaptD = adaptQ;
    if (strobes.applyStep) begin
      if (fireNow)
        adaptD = adaptSum[ADAPT_W] ? {ADAPT_W{1'b1}} : adaptSum[ADAPT_W-1:0];
      else
        adaptD = adaptDecayed;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memQ   <= '0;
      adaptQ <= '0;
    end else begin
      memQ   <= memD;
      adaptQ <= adaptD;
    end
  end

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !tick) |=> $stable(memQ)); // R1

  AST_ADAPT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    fireNow |=> (adaptQ >= $past(cfgAdaptInc))); // R6

endmodule

// File: rtl/alif_neuron.sv
module alif_neuron
  import alif_pkg::*;
#(
  parameter int MEM_W   = 16,
  parameter int IN_W    = 12,
  parameter int ADAPT_W = 12,
  parameter int REF_W   = 6,
  parameter int SHIFT_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic signed [IN_W-1:0] inCurrent,
  input  logic                   tick,
  input  logic [MEM_W-1:0]       cfgLeak,
  input  logic [MEM_W-1:0]       cfgThresh,
  input  logic [REF_W-1:0]       cfgRefrac,
  input  logic [ADAPT_W-1:0]     cfgAdaptInc,
  input  logic [SHIFT_W-1:0]     cfgAdaptShift,
  output logic                   spike,
  output logic [MEM_W-1:0]       membrane
);
  ctlStrobes_t strobes;
  logic        fireNow;
  logic        overThresh;
  logic        refBusy;

  alif_ctrl #(.REF_W(REF_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .tick       (tick),
    .overThresh (overThresh),
    .cfgRefrac  (cfgRefrac),
    .strobes    (strobes),
    .fireNow    (fireNow),
    .refBusy    (refBusy),
    .spikeQ     (spike)
  );

  alif_datapath #(
    .MEM_W(MEM_W), .IN_W(IN_W), .ADAPT_W(ADAPT_W), .SHIFT_W(SHIFT_W)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .fireNow       (fireNow),
    .inValid       (inValid),
    .tick          (tick),
    .inCurrent     (inCurrent),
    .cfgLeak       (cfgLeak),
    .cfgThresh     (cfgThresh),
    .cfgAdaptInc   (cfgAdaptInc),
    .cfgAdaptShift (cfgAdaptShift),
    .overThresh    (overThresh),
    .memQ          (membrane)
  );

  AST_SPIKE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    spike |-> $past(tick)); // R4

  AST_SPIKE_CLEARS_MEM: assert property (@(posedge clk) disable iff (!rstN)
    spike |-> (membrane == '0)); // R4

  AST_REFRAC_HOLDS_REST: assert property (@(posedge clk) disable iff (!rstN)
    refBusy |=> (membrane == '0)); // R5

endmodule

// File: tb/sim_alif_neuron.sv
module sim_alif_neuron;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic               v;
    logic signed [11:0] c;
    logic               t;
    logic [15:0]        m;
    logic               s;
  } vec_t;

  // Config: leak 2, thresh 50, refrac 2, adapt inc 10, shift 1.
  localparam vec_t VECS [17] = '{
    '{1'b1,  12'sd20,  1'b0, 16'd20, 1'b0},  // R1 add
    '{1'b1, -12'sd5,   1'b0, 16'd15, 1'b0},  // R1 signed subtract
    '{1'b0,  12'sd0,   1'b1, 16'd13, 1'b0},  // R2 leak
    '{1'b1,  12'sd40,  1'b0, 16'd53, 1'b0},  // R1
    '{1'b0,  12'sd0,   1'b1, 16'd0,  1'b1},  // R4 fire 51>=50
    '{1'b1,  12'sd30,  1'b0, 16'd0,  1'b0},  // R5 ignored
    '{1'b0,  12'sd0,   1'b1, 16'd0,  1'b0},  // R5 refrac 2->1
    '{1'b1,  12'sd30,  1'b0, 16'd0,  1'b0},  // R5 still ignored
    '{1'b0,  12'sd0,   1'b1, 16'd0,  1'b0},  // R5 refrac 1->0
    '{1'b1,  12'sd60,  1'b0, 16'd60, 1'b0},  // R5 accepted again
    '{1'b0,  12'sd0,   1'b1, 16'd0,  1'b1},  // R6 60-2-2=56 fires
    '{1'b1, -12'sd100, 1'b0, 16'd0,  1'b0},  // R5 ignored
    '{1'b0,  12'sd0,   1'b1, 16'd0,  1'b0},  // adapt 11->5
    '{1'b0,  12'sd0,   1'b1, 16'd0,  1'b0},  // adapt 5->2
    '{1'b1,  12'sd45,  1'b1, 16'd41, 1'b0},  // R2 R6 45-2-2
    '{1'b1, -12'sd100, 1'b0, 16'd0,  1'b0},  // R2 floor at zero
    '{1'b0,  12'sd0,   1'b1, 16'd0,  1'b0}   // R2 floor on tick
  };

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               inValid = 1'b0;
  logic signed [11:0] inCurrent = '0;
  logic               tick = 1'b0;
  logic [15:0]        cfgLeak = '0;
  logic [15:0]        cfgThresh = '0;
  logic [5:0]         cfgRefrac = '0;
  logic [11:0]        cfgAdaptInc = '0;
  logic [3:0]         cfgAdaptShift = '0;
  logic               spike;
  logic [15:0]        membrane;

  int nChecks = 0;
  int nFail   = 0;

  always #(PERIOD/2) clk = ~clk;

  alif_neuron u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCurrent(inCurrent),
    .tick(tick), .cfgLeak(cfgLeak), .cfgThresh(cfgThresh),
    .cfgRefrac(cfgRefrac), .cfgAdaptInc(cfgAdaptInc),
    .cfgAdaptShift(cfgAdaptShift), .spike(spike), .membrane(membrane)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus; return just after the capturing edge.
  task automatic cyc(input logic v, input logic signed [11:0] c, input logic t);
    @(negedge clk);
    inValid = v; inCurrent = c; tick = t;
    @(posedge clk);
    #1;
    inValid = 1'b0; tick = 1'b0; inCurrent = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int cnt0;
    int cnt1;
    doReset();
    #1;
    chk("R8 reset spike", int'(spike), 0);
    chk("R8 reset membrane", int'(membrane), 0);

    // Vector walk.
    cfgLeak = 16'd2; cfgThresh = 16'd50; cfgRefrac = 6'd2;
    cfgAdaptInc = 12'd10; cfgAdaptShift = 4'd1;
    for (int i = 0; i < 17; i++) begin
      cyc(VECS[i].v, VECS[i].c, VECS[i].t);
      chk($sformatf("R1/R2/R4/R5/R6 vec%0d membrane", i), int'(membrane), int'(VECS[i].m));
      chk($sformatf("R4/R5 vec%0d spike", i), int'(spike), int'(VECS[i].s));
    end

    // R3: saturation at the ceiling, then count down from it.
    doReset();
    cfgLeak = '0; cfgThresh = 16'hFFFF; cfgAdaptInc = '0; cfgRefrac = '0;
    for (int i = 0; i < 33; i++) cyc(1'b1, 12'sd2047, 1'b0);
    chk("R3 clamp high", int'(membrane), 65535);
    cyc(1'b1, -12'sd1, 1'b0);
    chk("R3 no wrap", int'(membrane), 65534);

    // R7: threshold change applies at next tick.
    doReset();
    cfgThresh = 16'd50;
    cyc(1'b1, 12'sd30, 1'b0);
    cyc(1'b0, 12'sd0, 1'b1);
    chk("R7 below old threshold spike", int'(spike), 0);
    chk("R7 below old threshold membrane", int'(membrane), 30);
    cfgThresh = 16'd25;
    cyc(1'b0, 12'sd0, 1'b1);
    chk("R7 new threshold fires", int'(spike), 1);
    chk("R7 membrane cleared", int'(membrane), 0);

    // R5: zero refractory length allows back-to-back firing.
    cfgThresh = 16'd10; cfgRefrac = '0;
    cyc(1'b1, 12'sd20, 1'b1);
    chk("R5 zero refrac first spike", int'(spike), 1);
    cyc(1'b1, 12'sd20, 1'b1);
    chk("R5 zero refrac second spike", int'(spike), 1);
    cyc(1'b0, 12'sd0, 1'b0);
    chk("R4 spike lasts one cycle", int'(spike), 0);

    // R9: adaptation lowers the rate under sustained drive.
    doReset();
    cfgLeak = '0; cfgThresh = 16'd100; cfgRefrac = '0;
    cfgAdaptShift = 4'd3; cfgAdaptInc = '0;
    cnt0 = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1'b1, 12'sd30, 1'b1);
      if (spike) cnt0++;
    end
    chk("R9 no adaptation spike count", cnt0, 10);
    doReset();
    cfgAdaptInc = 12'd40;
    cnt1 = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1'b1, 12'sd30, 1'b1);
      if (spike) cnt1++;
    end
    chk("R9 adaptation reduces rate", int'(cnt1 < cnt0), 1);
    chk("R9 adaptation still fires", int'(cnt1 > 0), 1);

    summary();
  end
endmodule